// File: doc/BRIEF.md
# Eight-Bit ALU with Not-Borrow Carry and Flag Register

This block is the arithmetic and logic datapath of a small 8-bit processor core. It takes two operands, a bit index, the current accumulator value and a four-bit operation code. In the same cycle it returns the result, the accumulator value and the next condition flags. Separate write-enable outputs tell the surrounding register file whether the destination, the accumulator or both take the new value.

The carry (C), overflow (V) and zero (Z) flags are held in a small register inside the block. The carry flag feeds back as the carry-in for the chained add and subtract forms. On subtraction the carry is a not-borrow: C is 1 when no borrow occurred. Two subtract directions are provided, operand one minus operand two and the reversed form. Compare writes no register and reports its order through C and V. The flag-pack operation copies C and C XOR V into the two top bits of the accumulator.

The datapath width is a parameter, 8 by default. The bit index is log2 of the width.

Top module: `alu8_core`

## Requirements
- R1: Opcode encoding on `op_i`: 0 AND, 1 OR, 2 XOR, 3 ADD, 4 ADDC, 5 SUB, 6 SUBB, 7 RSUB, 8 RSUBB, 9 CMPU, 10 CMPS, 11 BTST, 12 BSET, 13 BCLR, 14 BINV, 15 FPACK. AND, OR and XOR return the bitwise result of `op1_i` and `op2_i`. The result goes to both `res_o` and `acc_o`, with both write enables high. Z is set when the result is zero, and C and V keep their values.
- R2: ADD returns op1+op2 and ADDC returns op1+op2+C, modulo 2^W. C is the carry out of the top bit, V is two's-complement overflow and Z marks a zero result. Both outputs are written.
- R3: SUB returns op1−op2 and SUBB returns op1−op2−(1−C). C is 1 exactly when no borrow occurs, V is signed overflow and Z marks a zero result. Both outputs are written.
- R4: RSUB returns op2−op1 and RSUBB returns op2−op1−(1−C). The carry, overflow and zero rules are the same as in R3.
- R5: CMPU clears C when op2 > op1 unsigned and sets it otherwise. Z is set when op1 equals op2, and V = C AND NOT Z. Both write enables are low.
- R6: CMPS follows R5, but the ordering is two's-complement signed.
- R7: BTST sets Z to the inverse of bit `bit_idx_i` of op1. C and V keep their values, and both write enables are low.
- R8: BSET, BCLR and BINV set, clear or toggle bit `bit_idx_i` of op1. The modified value goes to both `res_o` and `acc_o`, with both write enables high. Z marks a zero modified value, and C and V keep their values.
- R9: FPACK drives `acc_o` as `acc_i` with its top bit replaced by C and the next bit replaced by C XOR V. `acc_we_o` is high, `res_we_o` is low, and all flags keep their values.
- R10: The flags load the next values on a rising clock edge only while `flag_en_i` is high. Otherwise they hold. `flags_o` is {C, V, Z}, with C in bit 2.
- R11: An active-low reset clears C, V and Z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| op1_i | input | W | First operand |
| op2_i | input | W | Second operand |
| bit_idx_i | input | log2(W) | Bit index for the bit operations |
| acc_i | input | W | Current accumulator value |
| flag_en_i | input | 1 | Flag register load enable |
| res_o | output | W | Result for the destination register |
| res_we_o | output | 1 | Destination write enable |
| acc_o | output | W | New accumulator value |
| acc_we_o | output | 1 | Accumulator write enable |
| flags_o | output | 3 | Registered flags {C, V, Z} |

## Verification
The bench builds the block with W = 4, so that the bit index is two bits wide. At that width every operand pair can be applied with every opcode, against four preloaded flag states. Those states are C/V/Z = 101, 000, 010 and 111. The sweep therefore covers both carry-in values, every signed-overflow and borrow boundary, equal and reversed-order compares, and every bit position. It also gives FPACK every combination of C and V. After each operation an extra cycle with the enable low confirms that the flags hold.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_AND   = 4'd0,
    OP_OR    = 4'd1,
    OP_XOR   = 4'd2,
    OP_ADD   = 4'd3,
    OP_ADDC  = 4'd4,
    OP_SUB   = 4'd5,
    OP_SUBB  = 4'd6,
    OP_RSUB  = 4'd7,
    OP_RSUBB = 4'd8,
    OP_CMPU  = 4'd9,
    OP_CMPS  = 4'd10,
    OP_BTST  = 4'd11,
    OP_BSET  = 4'd12,
    OP_BCLR  = 4'd13,
    OP_BINV  = 4'd14,
    OP_FPACK = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
  } alu_flags_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic           c_i,
  output logic [W-1:0]   sum_o,
  output logic           c_o,
  output logic           v_o,
  output logic           z_o
);

  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   full;
  logic         ovf, zero, lt_s;

  // one adder: subtraction is x + ~y + cin, carry-out is not-borrow
  always_comb begin
    x   = a_i;
    y   = b_i;
    cin = 1'b0;
    unique case (op_i)
      OP_ADD:   begin x = a_i; y = b_i;  cin = 1'b0; end
      OP_ADDC:  begin x = a_i; y = b_i;  cin = c_i;  end
      OP_SUB:   begin x = a_i; y = ~b_i; cin = 1'b1; end
      OP_SUBB:  begin x = a_i; y = ~b_i; cin = c_i;  end
      OP_RSUB:  begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_RSUBB: begin x = b_i; y = ~a_i; cin = c_i;  end
      OP_CMPU,
      OP_CMPS:  begin x = a_i; y = ~b_i; cin = 1'b1; end
      default:  begin x = a_i; y = b_i;  cin = 1'b0; end
    endcase
  end

  assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum_o = full[W-1:0];
  assign ovf   = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
  assign zero  = (full[W-1:0] == '0);
  assign lt_s  = full[W-1] ^ ovf;

  always_comb begin
    z_o = zero;
    unique case (op_i)
      OP_CMPU: begin c_o = full[W];  v_o = full[W] & ~zero; end
      OP_CMPS: begin c_o = ~lt_s;    v_o = ~lt_s & ~zero;   end
      default: begin c_o = full[W];  v_o = ovf;             end
    endcase
  end

endmodule

// File: rtl/alu8_bitlog.sv
module alu8_bitlog
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [IW-1:0]  idx_i,
  output logic [W-1:0]   res_o,
  output logic           z_o
);

  logic [W-1:0] mask;

  assign mask = {{(W-1){1'b0}}, 1'b1} << idx_i;

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_BSET: res_o = a_i | mask;
      OP_BCLR: res_o = a_i & ~mask;
      OP_BINV: res_o = a_i ^ mask;
      default: res_o = a_i;
    endcase
  end

  // test reads the selected bit; the rest report a zero result
  assign z_o = (op_i == OP_BTST) ? ((a_i & mask) == '0) : (res_o == '0);

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  alu_flags_t d_i,
  output alu_flags_t q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R10

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RST_CLEAR: assert (q_o == '0); // R11
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [3:0]     op_i,
  input  logic [W-1:0]   op1_i,
  input  logic [W-1:0]   op2_i,
  input  logic [IW-1:0]  bit_idx_i,
  input  logic [W-1:0]   acc_i,
  input  logic           flag_en_i,
  output logic [W-1:0]   res_o,
  output logic           res_we_o,
  output logic [W-1:0]   acc_o,
  output logic           acc_we_o,
  output logic [2:0]     flags_o
);

  alu_op_e    op;
  alu_flags_t flags_q, flags_nxt;
  logic [W-1:0] ar_sum, bl_res;
  logic ar_c, ar_v, ar_z, bl_z;
  logic is_logic, is_arith, is_cmp, is_tst, is_bmod, is_fpack;

  assign op = alu_op_e'(op_i);

  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) ||
                    (op == OP_SUBB) || (op == OP_RSUB) || (op == OP_RSUBB);
  assign is_cmp   = (op == OP_CMPU) || (op == OP_CMPS);
  assign is_tst   = (op == OP_BTST);
  assign is_bmod  = (op == OP_BSET) || (op == OP_BCLR) || (op == OP_BINV);
  assign is_fpack = (op == OP_FPACK);

  alu8_arith #(.W(W)) u_arith (
    .op_i  (op),
    .a_i   (op1_i),
    .b_i   (op2_i),
    .c_i   (flags_q.c),
    .sum_o (ar_sum),
    .c_o   (ar_c),
    .v_o   (ar_v),
    .z_o   (ar_z)
  );

  alu8_bitlog #(.W(W), .IW(IW)) u_bitlog (
    .op_i  (op),
    .a_i   (op1_i),
    .b_i   (op2_i),
    .idx_i (bit_idx_i),
    .res_o (bl_res),
    .z_o   (bl_z)
  );

  always_comb begin
    flags_nxt = flags_q;
    if (is_arith || is_cmp) begin
      flags_nxt.c = ar_c;
      flags_nxt.v = ar_v;
      flags_nxt.z = ar_z;
    end else if (is_logic || is_tst || is_bmod) begin
      flags_nxt.z = bl_z;
    end
  end

  assign res_o    = (is_arith || is_cmp) ? ar_sum : bl_res;
  assign res_we_o = is_logic || is_arith || is_bmod;
  assign acc_we_o = res_we_o || is_fpack;
  assign acc_o    = is_fpack ? {flags_q.c, flags_q.c ^ flags_q.v, acc_i[W-3:0]}
                             : res_o;

  alu8_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (flag_en_i),
    .d_i    (flags_nxt),
    .q_o    (flags_q)
  );

  assign flags_o = flags_q;

  AST_LOGIC_CV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && is_logic) |=> flags_o[2:1] == $past(flags_o[2:1])); // R1
  AST_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ADD) |-> flags_nxt.c == ((({1'b0, op1_i} + {1'b0, op2_i}) >> W) != 0)); // R2
  AST_SUB_NOBORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SUB) |-> flags_nxt.c == (op1_i >= op2_i)); // R3
  AST_RSUB_NOBORROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RSUB) |-> flags_nxt.c == (op2_i >= op1_i)); // R4
  AST_CMPU_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CMPU) |-> flags_nxt.c == !(op2_i > op1_i)); // R5
  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmp |-> !res_we_o && !acc_we_o); // R5
  AST_CMPS_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_CMPS) |-> flags_nxt.c == !($signed(op2_i) > $signed(op1_i))); // R6
  AST_TST_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_tst |-> flags_nxt.z == !op1_i[bit_idx_i]); // R7
  AST_BIT_CV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && is_bmod) |=> flags_o[2:1] == $past(flags_o[2:1])); // R8
  AST_FPACK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_en_i && is_fpack) |=> $stable(flags_o)); // R9

endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;

  localparam int W  = 4;
  localparam int IW = 2;
  localparam int M  = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic [3:0] op_i = '0;
  logic [W-1:0] op1_i = '0, op2_i = '0, acc_i = '0;
  logic [IW-1:0] bit_idx_i = '0;
  logic flag_en_i = 1'b0;
  logic [W-1:0] res_o, acc_o;
  logic res_we_o, acc_we_o;
  logic [2:0] flags_o;

  int n_chk = 0, n_fail = 0;
  int mc = 0, mv = 0, mz = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu8_core #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .op1_i(op1_i), .op2_i(op2_i),
    .bit_idx_i(bit_idx_i), .acc_i(acc_i), .flag_en_i(flag_en_i),
    .res_o(res_o), .res_we_o(res_we_o), .acc_o(acc_o), .acc_we_o(acc_we_o),
    .flags_o(flags_o)
  );

  function automatic int sg(input int x);
    return (x >= M/2) ? x - M : x;
  endfunction

  function automatic string req_of(input int op);
    if (op <= 2) return "R1";
    if (op <= 4) return "R2";
    if (op <= 6) return "R3";
    if (op <= 8) return "R4";
    if (op == 9) return "R5";
    if (op == 10) return "R6";
    if (op == 11) return "R7";
    if (op <= 14) return "R8";
    return "R9";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int op, input int a, input int b,
                        input int idx, input int acc, input bit en);
    int er, rwe, eacc, awe, ec, ev, ez, x, y, bin, d, s, cin;
    ec = mc; ev = mv; ez = mz; er = 0; rwe = 0; eacc = 0; awe = 0;
    case (op)
      0, 1, 2: begin
        er = (op == 0) ? (a & b) : (op == 1) ? (a | b) : (a ^ b);
        rwe = 1; ez = (er == 0);
      end
      3, 4: begin
        cin = (op == 4) ? mc : 0;
        s = a + b + cin; er = s % M; ec = (s >= M);
        s = sg(a) + sg(b) + cin; ev = (s > M/2-1 || s < -M/2);
        rwe = 1; ez = (er == 0);
      end
      5, 6, 7, 8: begin
        x = (op <= 6) ? a : b; y = (op <= 6) ? b : a;
        bin = (op == 6 || op == 8) ? 1 - mc : 0;
        d = x - y - bin; er = (d + 2*M) % M; ec = (d >= 0);
        d = sg(x) - sg(y) - bin; ev = (d > M/2-1 || d < -M/2);
        rwe = 1; ez = (er == 0);
      end
      9, 10: begin
        if (op == 9) ec = !(b > a); else ec = !(sg(b) > sg(a));
        ez = (a == b); ev = ec && !ez;
      end
      11: ez = !((a >> idx) & 1);
      12, 13, 14: begin
        er = (op == 12) ? (a | (1 << idx)) :
             (op == 13) ? (a & ~(1 << idx) & (M-1)) : (a ^ (1 << idx));
        rwe = 1; ez = (er == 0);
      end
      default: begin
        eacc = (mc << 3) | ((mc ^ mv) << 2) | (acc & 3); awe = 1;
      end
    endcase
    if (rwe) begin eacc = er; awe = 1; end
    @(negedge clk);
    op_i = 4'(op); op1_i = 4'(a); op2_i = 4'(b); bit_idx_i = 2'(idx);
    acc_i = 4'(acc); flag_en_i = en;
    #1;
    chk((res_we_o == rwe[0]) && (acc_we_o == awe[0]) &&
        (!rwe || res_o == er[3:0]) && (!awe || acc_o == eacc[3:0]),
        req_of(op), "outputs {rwe,awe,res,acc}",
        {res_we_o, acc_we_o, res_o, acc_o}, (rwe << 9) | (awe << 8) | (er << 4) | eacc);
    @(posedge clk);
    #1;
    if (en) begin
      chk(flags_o == 3'((ec << 2) | (ev << 1) | ez), req_of(op), "flags",
          flags_o, (ec << 2) | (ev << 1) | ez);
      mc = ec; mv = ev; mz = ez;
    end else begin
      chk(flags_o == 3'((mc << 2) | (mv << 1) | mz), "R10", "flags held",
          flags_o, (mc << 2) | (mv << 1) | mz);
    end
  endtask

  task automatic preset(input int p);
    case (p)
      0: run_op(5, 0, 0, 0, 0, 1'b1);
      1: run_op(5, 0, 1, 0, 0, 1'b1);
      2: run_op(3, 4, 4, 0, 0, 1'b1);
      default: run_op(3, 8, 8, 0, 0, 1'b1);
    endcase
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(flags_o == 3'b000, "R11", "flags in reset", flags_o, 0);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    chk(flags_o == 3'b000, "R11", "flags after reset", flags_o, 0);
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          for (int op = 0; op < 16; op++) begin
            preset(p);
            run_op(op, a, b, b & 3, (a * 3 + b) & (M-1), 1'b1);
            run_op(5, b, a ^ 1, 0, 0, 1'b0); // R10 hold with enable low
          end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule